// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits in front of the page-write controller of an electrically erasable memory and watches every write strobe (address plus data). It looks for short keyed command sequences. A three-write sequence arms protection. A six-write sequence lifts it. While protection is on, a write is stored only when the three-write key prefix comes before it in the same page load. A write without that prefix still makes the page controller run a programming period, but it stores nothing.

Command writes are never passed on for storage. A completed sequence does not change the protection flag at once. It only records a pending change, which takes effect when the page controller reports the end of the programming period. This holds even when no data follows the sequence. The protection flag models nonvolatile state. A soft reset leaves it alone, and only a separate clear input, used for the first power-up, forces it to the unprotected state.

All keys compare address bits 14..0 and data bits 7..0. Wider address or data bits are not looked at. A partial sequence is thrown away when a write does not match the next step, and also when the inter-write load window runs out.

Top module: `wp_seq_detect`

## Requirements
- R1: While `nv_clear` is high, the protection flag goes low at the next edge, and it stays low until a disable/enable change is applied. The initial state is unprotected.
- R2: While unprotected, a write that is not a command write gives `allow_o`=1 and `burn_o`=0 in its strobe cycle.
- R3: The enable key is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Every write that is a step of a sequence gives `allow_o`=0 and `burn_o`=0.
- R4: A completed enable sequence sets `protect_o` at the clock edge where `prog_done` is high, and not before that edge.
- R5: While protected, a non-command write outside an unlocked load gives `burn_o`=1 and `allow_o`=0.
- R6: After a completed key sequence, non-command writes give `allow_o`=1 until the load window expires. Once it has expired, R5 applies again.
- R7: The disable key is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Once complete, `protect_o` clears at the edge where `prog_done` is high.
- R8: A write that does not match the expected step ends the partial sequence and is handled as an ordinary write. The exception is a write of 0xAA at 0x5555: it is a command write and restarts the sequence at step one.
- R9: If `WINDOW_CYC` clock edges pass with no strobe while a load is open, the partial sequence and the unlock are discarded.
- R10: A soft reset (`rst`) clears the partial sequence, the unlock and any pending change, and leaves `protect_o` unchanged.
- R11: When `prog_done` comes in the same cycle as the write that completes a sequence, the earlier pending change is applied at that edge. The new change is applied at the next `prog_done`.
- R12: Address bits above 14 and data bits above 7 have no effect on key matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous soft reset, active high; keeps protection state |
| nv_clear | input | 1 | Synchronous first-power-up clear of the protection state |
| wr_stb | input | 1 | One write strobe per cycle in which it is high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| prog_done | input | 1 | End of a programming period, from the page controller |
| protect_o | output | 1 | Protection state flag |
| allow_o | output | 1 | Store this write (combinational, strobe cycle) |
| burn_o | output | 1 | Start the programming timer, store nothing (combinational, strobe cycle) |

## Verification
Two things can happen at the same clock edge. A completing command write can arrive together with a `prog_done` that commits an earlier pending change. The bench provokes this by finishing an enable sequence and letting its load close, then driving the last disable write in the very cycle that `prog_done` is high. It expects the flag to rise at that edge and fall only at the following `prog_done`. The bench also places a strobe on the edge where the load window would otherwise expire, and expects the strobe to keep the load open.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

    localparam int KEY_AW = 15;
    localparam int KEY_DW = 8;

    typedef struct packed {
        logic [KEY_AW-1:0] addr;
        logic [KEY_DW-1:0] data;
    } key_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_D3   = 3'd3,
        ST_D4   = 3'd4,
        ST_D5   = 3'd5
    } step_e;

    typedef struct packed {
        logic is_cmd;
        logic en_done;
        logic dis_done;
    } match_t;

    localparam key_t KEY_LEAD  = '{addr: 15'h5555, data: 8'hAA};
    localparam key_t KEY_SECND = '{addr: 15'h2AAA, data: 8'h55};
    localparam key_t KEY_ARM   = '{addr: 15'h5555, data: 8'hA0};
    localparam key_t KEY_ERASE = '{addr: 15'h5555, data: 8'h80};
    localparam key_t KEY_LIFT  = '{addr: 15'h5555, data: 8'h20};

    function automatic logic key_hit(input key_t seen, input key_t want);
        return (seen.addr == want.addr) && (seen.data == want.data);
    endfunction

endpackage

// File: rtl/wp_key_matcher.sv
module wp_key_matcher
    import wp_seq_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  logic   expire,
    input  logic   stb,
    input  key_t   key,
    output match_t res
);
    step_e step, nxt;

    logic h_lead, h_sec, h_arm, h_erase, h_lift;
    assign h_lead  = key_hit(key, KEY_LEAD);
    assign h_sec   = key_hit(key, KEY_SECND);
    assign h_arm   = key_hit(key, KEY_ARM);
    assign h_erase = key_hit(key, KEY_ERASE);
    assign h_lift  = key_hit(key, KEY_LIFT);

    always_comb begin
        nxt = ST_IDLE;
        res = '0;
        unique case (step)
            ST_K1:   if (h_sec)   begin nxt = ST_K2; res.is_cmd = 1'b1; end
            ST_K2:   if (h_arm)   begin nxt = ST_IDLE; res.is_cmd = 1'b1; res.en_done = 1'b1; end
                     else if (h_erase) begin nxt = ST_D3; res.is_cmd = 1'b1; end
            ST_D3:   if (h_lead)  begin nxt = ST_D4; res.is_cmd = 1'b1; end
            ST_D4:   if (h_sec)   begin nxt = ST_D5; res.is_cmd = 1'b1; end
            ST_D5:   if (h_lift)  begin nxt = ST_IDLE; res.is_cmd = 1'b1; res.dis_done = 1'b1; end
            default: ;
        endcase
        // mismatch: restart on the lead key, otherwise an ordinary write
        if (!res.is_cmd && h_lead) begin
            nxt = ST_K1;
            res.is_cmd = 1'b1;
        end
        if (!stb) res = '0;
    end

    always_ff @(posedge clk) begin
        if (clr || expire) step <= ST_IDLE;
        else if (stb)      step <= nxt;
    end

    // R9: an expired window leaves no partial sequence
    a_r9_expire_flush: assert property (@(posedge clk) disable iff (clr)
        expire |=> step == ST_IDLE);

    // R8: a non-command write leaves the matcher idle
    a_r8_mismatch_idle: assert property (@(posedge clk) disable iff (clr)
        (stb && !res.is_cmd) |=> step == ST_IDLE);

    // R3: a completion is always a command write
    a_r3_done_is_cmd: assert property (@(posedge clk) disable iff (clr)
        (res.en_done || res.dis_done) |-> res.is_cmd);

endmodule

// File: rtl/wp_load_window.sv
module wp_load_window #(
    parameter int WINDOW_CYC = 150
) (
    input  logic clk,
    input  logic clr,
    input  logic stb,
    output logic expire
);
    localparam int CW = $clog2(WINDOW_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(WINDOW_CYC - 1);

    logic          load_act;
    logic [CW-1:0] cnt;

    assign expire = load_act && !stb && (cnt == LIM);

    always_ff @(posedge clk) begin
        if (clr) begin
            load_act <= 1'b0;
            cnt      <= '0;
        end else if (stb) begin
            load_act <= 1'b1;
            cnt      <= '0;
        end else if (expire) begin
            load_act <= 1'b0;
            cnt      <= '0;
        end else if (load_act) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: counter never passes the window limit
    a_r9_window_bound: assert property (@(posedge clk) disable iff (clr)
        cnt <= LIM);

    // R9: an expiry closes the load
    a_r9_close: assert property (@(posedge clk) disable iff (clr)
        expire |=> !load_act);

endmodule

// File: rtl/wp_protect_state.sv
module wp_protect_state
    import wp_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   nv_clear,
    input  logic   stb,
    input  match_t res,
    input  logic   expire,
    input  logic   prog_done,
    output logic   protect,
    output logic   allow,
    output logic   burn
);
    logic pend_v, pend_val, session;

    assign allow = stb && !res.is_cmd && (!protect || session);
    assign burn  = stb && !res.is_cmd && protect && !session;

    always_ff @(posedge clk) begin
        if (nv_clear) begin
            protect <= 1'b0;
            pend_v  <= 1'b0;
            pend_val <= 1'b0;
            session <= 1'b0;
        end else if (rst) begin
            pend_v  <= 1'b0;
            session <= 1'b0;
        end else begin
            if (prog_done && pend_v) begin
                protect <= pend_val;
                pend_v  <= 1'b0;
            end
            if (res.en_done || res.dis_done) begin
                pend_v   <= 1'b1;
                pend_val <= res.en_done;
                session  <= 1'b1;
            end else if (expire) begin
                session <= 1'b0;
            end
        end
    end

    // R3: command writes are neither stored nor burned
    a_r3_cmd_not_stored: assert property (@(posedge clk) disable iff (rst)
        res.is_cmd |-> !allow && !burn);

    // R5: a burn happens only in the protected state
    a_r5_burn_only_prot: assert property (@(posedge clk) disable iff (rst)
        burn |-> protect && !allow);

    // R4: the flag moves only on a finished period or a clear
    a_r4_change_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(protect) |-> $past(prog_done) || $past(nv_clear));

    // R1: clear forces the unprotected state
    a_r1_clear: assert property (@(posedge clk)
        nv_clear |=> !protect);

    // R10: soft reset keeps the flag
    a_r10_soft_keeps: assert property (@(posedge clk) disable iff (nv_clear)
        rst |=> $stable(protect));

endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int WINDOW_CYC = 150
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nv_clear,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_done,
    output logic              protect_o,
    output logic              allow_o,
    output logic              burn_o
);
    logic   soft_clr, expire;
    key_t   key;
    match_t res;

    assign soft_clr = rst || nv_clear;
    assign key.addr = wr_addr[KEY_AW-1:0];
    assign key.data = wr_data[KEY_DW-1:0];

    wp_load_window #(.WINDOW_CYC(WINDOW_CYC)) u_win (
        .clk(clk), .clr(soft_clr), .stb(wr_stb), .expire(expire)
    );

    wp_key_matcher u_match (
        .clk(clk), .clr(soft_clr), .expire(expire),
        .stb(wr_stb), .key(key), .res(res)
    );

    wp_protect_state u_state (
        .clk(clk), .rst(rst), .nv_clear(nv_clear), .stb(wr_stb),
        .res(res), .expire(expire), .prog_done(prog_done),
        .protect(protect_o), .allow(allow_o), .burn(burn_o)
    );

    // R2: store and burn never both
    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(allow_o && burn_o));

endmodule

// File: tb/wp_seq_detect_test.sv
module wp_seq_detect_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 16;
    localparam int WIN = 8;

    logic clk = 1'b0;
    logic rst = 1'b1, nv_clear = 1'b1, wr_stb = 1'b0, prog_done = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic protect_o, allow_o, burn_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_seq_detect #(.ADDR_W(AW), .DATA_W(DW), .WINDOW_CYC(WIN)) uut (
        .clk(clk), .rst(rst), .nv_clear(nv_clear), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
        .protect_o(protect_o), .allow_o(allow_o), .burn_o(burn_o)
    );

    task automatic chk_prot(input logic exp, input string tag);
        checks++;
        if (protect_o !== exp) begin
            errors++;
            $display("FAIL %s protect actual %0b expected %0b", tag, protect_o, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic ea, input logic eb, input logic done,
                      input string tag);
        wr_stb = 1'b1; wr_addr = a; wr_data = d; prog_done = done;
        #1;
        checks++;
        if (allow_o !== ea || burn_o !== eb) begin
            errors++;
            $display("FAIL %s addr %h data %h allow/burn actual %0b%0b expected %0b%0b",
                     tag, a, d, allow_o, burn_o, ea, eb);
        end
        @(negedge clk);
        wr_stb = 1'b0; prog_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done();
        prog_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0;
    endtask

    task automatic unlock(input string tag);
        wr(17'h05555, 16'h00AA, 0, 0, 0, tag);
        wr(17'h02AAA, 16'h0055, 0, 0, 0, tag);
        wr(17'h05555, 16'h00A0, 0, 0, 0, tag);
    endtask

    task automatic lift(input logic last_done, input string tag);
        wr(17'h05555, 16'h00AA, 0, 0, 0, tag);
        wr(17'h02AAA, 16'h0055, 0, 0, 0, tag);
        wr(17'h05555, 16'h0080, 0, 0, 0, tag);
        wr(17'h05555, 16'h00AA, 0, 0, 0, tag);
        wr(17'h02AAA, 16'h0055, 0, 0, 0, tag);
        wr(17'h05555, 16'h0020, 0, 0, last_done, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0; nv_clear = 1'b0;
        @(negedge clk);
        chk_prot(0, "R1 reset");

        // R2 / R3: sweep all data bytes at the lead address
        for (int d = 0; d < 256; d++) begin
            logic is_lead;
            is_lead = (d == 8'hAA);
            wr(17'h05555, 16'(d), !is_lead, 0, 0, is_lead ? "R3 lead sweep" : "R2 sweep");
        end
        idle(WIN + 2);

        // R12: upper address and data bits are ignored
        wr(17'h1D555, 16'hFFAA, 0, 0, 0, "R12 lead");
        wr(17'h1AAAA, 16'h3355, 0, 0, 0, "R12 second");
        wr(17'h05555, 16'h00A0, 0, 0, 0, "R3 arm");
        idle(WIN + 2);
        chk_prot(0, "R4 not before done");
        pulse_done();
        chk_prot(1, "R4 set");

        wr(17'h00123, 16'h005A, 0, 1, 0, "R5 burn");
        idle(2);

        // R6: unlocked load, then window expiry
        unlock("R6 prefix");
        wr(17'h00200, 16'h0011, 1, 0, 0, "R6 store");
        idle(WIN - 1);
        wr(17'h00201, 16'h0012, 1, 0, 0, "R6 edge of window");
        idle(WIN + 2);
        wr(17'h00202, 16'h0013, 0, 1, 0, "R6 after expiry");
        pulse_done();
        chk_prot(1, "R6 stays");

        // R8: mismatch and restart
        idle(WIN + 2);
        wr(17'h05555, 16'h00AA, 0, 0, 0, "R8 step1");
        wr(17'h02AAA, 16'h0055, 0, 0, 0, "R8 step2");
        wr(17'h05555, 16'h0012, 0, 1, 0, "R8 mismatch ordinary");
        wr(17'h05555, 16'h00AA, 0, 0, 0, "R8 step1");
        wr(17'h05555, 16'h00AA, 0, 0, 0, "R8 restart");
        wr(17'h02AAA, 16'h0055, 0, 0, 0, "R8 step2");
        wr(17'h05555, 16'h00A0, 0, 0, 0, "R8 arm");
        wr(17'h00300, 16'h0044, 1, 0, 0, "R8 store after restart");
        idle(WIN + 2);

        // R9: window expiry inside a sequence
        wr(17'h05555, 16'h00AA, 0, 0, 0, "R9 step1");
        wr(17'h02AAA, 16'h0055, 0, 0, 0, "R9 step2");
        idle(WIN + 2);
        wr(17'h05555, 16'h00A0, 0, 1, 0, "R9 stale arm");
        idle(WIN + 2);

        // R10: soft reset mid-sequence
        wr(17'h05555, 16'h00AA, 0, 0, 0, "R10 step1");
        wr(17'h02AAA, 16'h0055, 0, 0, 0, "R10 step2");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_prot(1, "R10 keeps flag");
        wr(17'h05555, 16'h00A0, 0, 1, 0, "R10 sequence dropped");
        idle(WIN + 2);

        // R7: disable
        lift(0, "R7 lift");
        wr(17'h00400, 16'h0077, 1, 0, 0, "R7 store in load");
        chk_prot(1, "R7 not before done");
        pulse_done();
        chk_prot(0, "R7 cleared");
        idle(WIN + 2);
        wr(17'h00401, 16'h0078, 1, 0, 0, "R7 ordinary after");

        // R11: completion and prog_done in the same cycle
        idle(WIN + 2);
        unlock("R11 arm");
        idle(WIN + 2);
        chk_prot(0, "R11 pending");
        lift(1, "R11 lift with done");
        chk_prot(1, "R11 old pending applied");
        pulse_done();
        chk_prot(0, "R11 new pending applied");

        // R1: clear after protection
        idle(WIN + 2);
        unlock("R1 arm");
        pulse_done();
        chk_prot(1, "R1 armed");
        nv_clear = 1'b1;
        @(negedge clk);
        nv_clear = 1'b0;
        chk_prot(0, "R1 clear");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule